// File: doc/BRIEF.md
# Memory Controller Performance Counter Bank

This block sits at the boundary of a memory controller and turns a wide vector of single-cycle performance event pulses into four 32-bit counts. Each of counters 1 to 3 has its own configuration word. That word holds an enable bit and an event code, and the code picks one bit of the event vector. When the counter is enabled, it adds one in every cycle that its selected bit is high.

Counter 0 is the time base. When it is enabled it counts clock cycles, and it ignores its event code. When it reaches its terminal value (all ones), the whole bank locks: no counter moves any further and the interrupt line goes high. Counters 1 to 3 wrap silently when they overflow.

Software works through a simple synchronous write port and a combinational read port. Through these it can configure the counters, preset any counter, read back the live or frozen values, and issue one clear. The clear zeroes every counter, releases the lock and drops the interrupt.

Top module: `pmc_bank`

## Requirements
- R1: After reset, all four counters read 0, every configuration word reads 0 (disabled, code 0), the status word reads 0 and `irq` is low.
- R2: An enabled counter 1, 2 or 3 whose configuration code is c (0 to 63, held in bits 7:0 of its configuration word) adds exactly 1 in each cycle in which `perf_evt[c]` is high. It is unaffected by every other event bit.
- R3: A counter whose enable bit (bit 8 of its configuration word) is 0 keeps its value, whatever the event inputs do.
- R4: When counter 0 is enabled, it adds 1 on every clock edge, whatever its event code is and whatever the event inputs are. A write that enables it takes effect from the next edge. The edge that captures a write disabling it still counts.
- R5: An event code of 64 or more makes counters 1 to 3 count nothing, even with all event bits high.
- R6: At the first edge on which counter 0 is enabled and holds 0xFFFF_FFFF, the bank locks and `irq` rises. From then on counter 0 stays at 0xFFFF_FFFF, and counters 1 to 3 keep the value they reached on that edge. This lasts until a clear.
- R7: Counters 1 to 3 step from 0xFFFF_FFFF to 0 and keep counting, and `irq` stays low.
- R8: Writing 1 to bit 0 at address 8 sets all four counters to 0, releases the lock and drops `irq` at that edge. Counter 0 resumes counting from the next edge if it is enabled.
- R9: A write to address 0 to 3 loads that counter with `wr_data` when the bank is not locked. While the bank is locked, such a write is ignored.
- R10: Read map: addresses 0 to 3 return counters 0 to 3. Addresses 4 to 7 return the configuration words of counters 0 to 3 (enable in bit 8, code in bits 7:0). Address 8 returns the lock state in bit 0. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| perf_evt | input | 64 | Single-cycle performance event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Timer-expiry interrupt, high while the bank is locked |

## Verification
The selection logic is driven with two different periodic pulse patterns on the two selected bits, while all the other bits are held high. A wrong index, or leakage from a neighbouring bit, then gives a count that differs from the expected one. The cases with all event bits high, with the counter disabled and with an out-of-range code are told apart from normal counting because each of them must leave the count at zero or unchanged. The timer is run with all events low and with a junk code, which shows that it counts cycles and not events. It is then started three cycles below its terminal value, with an event counter running beside it. The exact frozen values, a load attempted while locked, and the clear and restart pin down the lock timing to the cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int unsigned CNT_W    = 32;
  localparam int unsigned NUM_CNT  = 4;
  localparam int unsigned EVT_W    = 64;
  localparam int unsigned CODE_W   = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned IDX_W    = $clog2(NUM_CNT);
  localparam int unsigned CFG_BASE = NUM_CNT;
  localparam int unsigned CTRL_ADR = 2 * NUM_CNT;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } cnt_cfg_t;
endpackage

// File: rtl/pmc_evt_sel.sv
module pmc_evt_sel #(
  parameter int unsigned EVT_W  = 64,
  parameter int unsigned CODE_W = 8
) (
  input  logic [EVT_W-1:0]  evt,
  input  logic [CODE_W-1:0] code,
  output logic              hit
);
  localparam int unsigned SEL_W = $clog2(EVT_W);

  logic in_range;

  always_comb begin
    in_range = (32'(code) < EVT_W);
    hit      = in_range ? evt[code[SEL_W-1:0]] : 1'b0;
  end
endmodule

// File: rtl/pmc_counter.sv
module pmc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             freeze,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_ce = 1'b1;
    end else if (!freeze && load) begin
      cnt_d  = load_val;
      cnt_ce = 1'b1;
    end else if (!freeze && en && inc) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));
  a_r3_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr && !load) |=> $stable(cnt_q));
  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_W-1:0]  perf_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq
);
  cnt_cfg_t         cfg_q [NUM_CNT];
  cnt_cfg_t         cfg_d [NUM_CNT];
  logic             cfg_ce [NUM_CNT];
  logic [CNT_W-1:0] cnt   [NUM_CNT];
  logic [NUM_CNT-1:0] inc, ld;
  logic             lock_q, lock_d, clr, tmr_max;

  always_comb begin
    clr     = wr_en && (32'(wr_addr) == CTRL_ADR) && wr_data[0];
    tmr_max = &cnt[0];
    lock_d  = clr ? 1'b0 : (lock_q | (cfg_q[0].en & tmr_max));
    for (int i = 0; i < NUM_CNT; i++) begin
      ld[i]     = wr_en && (32'(wr_addr) == i);
      cfg_ce[i] = wr_en && (32'(wr_addr) == CFG_BASE + i);
      cfg_d[i]  = wr_data[CODE_W:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CNT; i++) cfg_q[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_CNT; i++)
        if (cfg_ce[i]) cfg_q[i] <= cfg_d[i];
    end
  end

  assign inc[0] = ~tmr_max;

  genvar g;
  generate
    for (g = 1; g < NUM_CNT; g++) begin : g_sel
      pmc_evt_sel #(.EVT_W(EVT_W), .CODE_W(CODE_W)) u_sel (
        .evt  (perf_evt),
        .code (cfg_q[g].code),
        .hit  (inc[g])
      );

      a_r5_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((32'(cfg_q[g].code) >= EVT_W) && !ld[g] && !clr) |=> $stable(cnt[g]));
    end

    for (g = 0; g < NUM_CNT; g++) begin : g_cnt
      pmc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (ld[g]),
        .load_val (wr_data),
        .en       (cfg_q[g].en),
        .freeze   (lock_q),
        .inc      (inc[g]),
        .cnt      (cnt[g])
      );
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    if (32'(rd_addr) < NUM_CNT)
      rd_data = cnt[rd_addr[IDX_W-1:0]];
    else if (32'(rd_addr) < CTRL_ADR)
      rd_data[CODE_W:0] = cfg_q[rd_addr[IDX_W-1:0]];
    else if (32'(rd_addr) == CTRL_ADR)
      rd_data[0] = lock_q;
  end

  assign irq = lock_q;

  a_r6_lock_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0].en && tmr_max && !clr) |=> irq);
  a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !clr) |=> lock_q);
  a_r7_only_timer_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(&cnt[0]));
  a_r4_timer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[0].en && !lock_q && !clr && !ld[0] && !tmr_max)
      |=> (cnt[0] == $past(cnt[0]) + 1'b1));
endmodule

// File: tb/test_pmc_bank.sv
`timescale 1ns/1ps
module test_pmc_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] perf_evt = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmc_bank i_pmc_bank (
    .clk(clk), .rst_n(rst_n), .perf_evt(perf_evt), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.2;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), v);
      check("R1 reset value", v, 32'h0);
      if (a % 4 == 3) idle(1);
    end
    check("R1 irq low", {31'b0, irq}, 32'h0);
    rd(4'd12, v);
    check("R10 unmapped read", v, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    int e1 = 0, e2 = 0;
    wr(4'd5, 32'h105);
    wr(4'd6, 32'h13F);
    rd(4'd5, v);
    check("R10 config readback", v, 32'h105);
    for (int k = 0; k < 20; k++) begin
      perf_evt = ~64'h0;
      perf_evt[5]  = (k % 3 == 0);
      perf_evt[63] = (k % 2 == 0);
      e1 += (k % 3 == 0);
      e2 += (k % 2 == 0);
      @(negedge clk);
    end
    perf_evt = '0;
    rd(4'd1, v); check("R2 counter1 code 5", v, 32'(e1));
    rd(4'd2, v); check("R2 counter2 code 63", v, 32'(e2));
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(4'd5, 32'h005);
    perf_evt = ~64'h0;
    idle(8);
    perf_evt = '0;
    rd(4'd1, v); check("R3 disabled hold", v, 32'd7);
  endtask

  task automatic t_timer;
    logic [31:0] v;
    wr(4'd4, 32'h133);
    idle(9);
    wr(4'd4, 32'h033);
    idle(2);
    rd(4'd0, v); check("R4 cycle count", v, 32'd10);
  endtask

  task automatic t_bad_code;
    logic [31:0] v;
    wr(4'd7, 32'h140);
    perf_evt = ~64'h0;
    idle(10);
    perf_evt = '0;
    rd(4'd3, v); check("R5 code 64", v, 32'd0);
    wr(4'd7, 32'h1C8);
    perf_evt = ~64'h0;
    idle(10);
    perf_evt = '0;
    rd(4'd3, v); check("R5 code 200", v, 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FFFE);
    rd(4'd2, v); check("R9 load", v, 32'hFFFF_FFFE);
    perf_evt[63] = 1'b1;
    idle(3);
    perf_evt = '0;
    rd(4'd2, v); check("R7 wrap", v, 32'd1);
    check("R7 no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(4'd8, 32'h1);
    for (int a = 0; a < 4; a++) begin
      rd(4'(a), v); check("R8 clear zero", v, 32'h0);
    end
    check("R8 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_expiry;
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFD);
    wr(4'd5, 32'h100);
    wr(4'd4, 32'h100);
    perf_evt[0] = 1'b1;
    idle(8);
    check("R6 irq high", {31'b0, irq}, 32'h1);
    rd(4'd8, v); check("R10 status lock", v, 32'h1);
    rd(4'd0, v); check("R6 timer frozen", v, 32'hFFFF_FFFF);
    rd(4'd1, v); check("R6 counter1 frozen", v, 32'd3);
    wr(4'd2, 32'h55);
    rd(4'd2, v); check("R9 load ignored while locked", v, 32'd0);
    perf_evt = '0;
    wr(4'd8, 32'h1);
    rd(4'd0, v); check("R8 timer cleared", v, 32'd0);
    rd(4'd1, v); check("R8 counter1 cleared", v, 32'd0);
    check("R8 irq dropped", {31'b0, irq}, 32'h0);
    idle(3);
    rd(4'd0, v); check("R8 timer resumes", v, 32'd3);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_select;
    t_disabled;
    t_timer;
    t_bad_code;
    t_wrap;
    t_clear;
    t_expiry;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule